// File: doc/BRIEF.md
# Sign-Preserving Minimum-Magnitude Combiner

This block merges a set of time-aligned, already normalised narrowband channel signals into a single sample stream, as the final stage of a clutter-suppression chain. For every sample index it looks at all channel values, finds the one with the smallest magnitude and forwards that value unchanged, sign included. The output therefore stays bipolar, which keeps it usable by downstream echo classifiers that need the waveform shape.

Each result is presented on an output stream together with the number of the winning channel. A record counter runs on the same results. A start pulse marks index 0, and a programmable count and window start choose which indices are stored. Stored results go into a dual-port result memory. The combiner owns the write port and the other port can be read at any time. The comparison runs as a balanced, pipelined tree with one register per level, and the valid information travels with the data.

Top module: `minmag_combiner`

## Requirements
- R1: For each valid input set, the output value is the channel sample of smallest magnitude among all channels, including the highest-numbered channel.
- R2: The output is the original signed sample of the winning channel, not its magnitude. A negative winner comes out negative.
- R3: When several channels share the smallest magnitude, the lowest-numbered one wins. `out_chan` reports the winner's channel number, where channel c is `in_data[c*16 +: 16]`.
- R4: The most negative code (-32768) is ranked as magnitude 32767. It ties with +32767, so the lower channel wins, and it loses to +32766.
- R5: `out_valid` rises exactly 5 cycles after the edge that samples `in_valid` (one input stage plus one per tree level). Each valid input yields exactly one output and idle cycles yield none.
- R6: `rec_start` latches `cfg_count` and `cfg_win_start`, and the sample accepted in the same cycle has index 0. An index i with win_start <= i < count is written at address i - win_start. Indices below the window and indices at or beyond count leave the memory untouched.
- R7: `rec_done` is high for exactly one cycle, in the cycle after the output of index count-1.
- R8: `rd_data` shows the word at `rd_addr` one cycle after the address is applied. When a read and a write hit the same address on the same edge, the read returns the previous content.
- R9: After reset `out_valid` and `rec_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_start | input | 1 | Marks the sample of this cycle as index 0 and latches the config |
| cfg_count | input | 13 | Number of indices in the record (0..4096) |
| cfg_win_start | input | 12 | First index that is stored |
| in_valid | input | 1 | Channel samples are valid |
| in_data | input | 192 | Twelve signed 16-bit channel samples, channel c at bits c*16 |
| out_valid | output | 1 | Output sample valid |
| out_sample | output | 16 | Selected signed sample |
| out_chan | output | 4 | Winning channel number |
| rec_done | output | 1 | One-cycle pulse after the last record index |
| rd_addr | input | 12 | Result memory read address |
| rd_data | output | 16 | Result memory read data, one cycle latency |

## Verification
The write port and the read port of the result memory can act on the same address on the same edge. The bench provokes this by holding the read address on a word that an earlier record filled, then sending a one-sample record that overwrites it. It checks that the cycle after the write edge still shows the old word and the following cycle shows the new one. A second collision, a tie in magnitude between channels of opposite sign, is judged on both the returned value and the reported channel.

// File: rtl/minmag_pkg.sv
package minmag_pkg;
    parameter int unsigned MM_SW   = 16;
    parameter int unsigned MM_NCH  = 12;
    localparam int unsigned MM_CHW  = (MM_NCH > 1) ? $clog2(MM_NCH) : 1;
    localparam int unsigned MM_MAGW = MM_SW - 1;
    localparam int unsigned MM_LVL  = $clog2(MM_NCH);
    localparam int unsigned MM_NP   = 1 << MM_LVL;
    localparam int unsigned MM_LAT  = MM_LVL + 1;

    localparam logic signed [MM_SW-1:0] MM_MOST_NEG = {1'b1, {(MM_SW-1){1'b0}}};
    localparam logic [MM_MAGW-1:0]      MM_MAG_MAX  = {MM_MAGW{1'b1}};

    typedef struct packed {
        logic                     live;
        logic [MM_CHW-1:0]        ch;
        logic [MM_MAGW-1:0]       mag;
        logic signed [MM_SW-1:0]  val;
    } cand_t;

    function automatic logic [MM_MAGW-1:0] mm_abs_sat(input logic signed [MM_SW-1:0] v);
        logic signed [MM_SW-1:0] neg;
        neg = -v;
        if (v == MM_MOST_NEG) return MM_MAG_MAX;
        else if (v[MM_SW-1])  return neg[MM_MAGW-1:0];
        else                  return v[MM_MAGW-1:0];
    endfunction
endpackage

// File: rtl/minmag_magnitude.sv
module minmag_magnitude
    import minmag_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [MM_NCH*MM_SW-1:0]  in_data,
    output cand_t                    leaves [MM_NP]
);
    for (genvar c = 0; c < MM_NP; c++) begin : g_leaf
        if (c < MM_NCH) begin : g_real
            logic signed [MM_SW-1:0] v;
            assign v = in_data[c*MM_SW +: MM_SW];
            always_ff @(posedge clk) begin
                if (rst) begin
                    leaves[c] <= '0;
                end else begin
                    leaves[c].live <= in_valid;
                    leaves[c].ch   <= MM_CHW'(c);
                    leaves[c].mag  <= mm_abs_sat(v);
                    leaves[c].val  <= v;
                end
            end
        end else begin : g_pad
            always_ff @(posedge clk) leaves[c] <= '0;
        end
    end
endmodule

// File: rtl/minmag_node.sv
module minmag_node
    import minmag_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cand_t a,
    input  cand_t b,
    output cand_t y
);
    logic take_b;
    assign take_b = b.live && (!a.live || (b.mag < a.mag));

    always_ff @(posedge clk) begin
        if (rst) y <= '0;
        else     y <= take_b ? b : a;
    end

    // R1
    min_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(a.live) && $past(b.live)) |->
            (y.mag <= $past(a.mag) && y.mag <= $past(b.mag)));

    // R3
    tie_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(a.live) && $past(b.live) && ($past(a.mag) == $past(b.mag))) |->
            (y.ch == $past(a.ch)));
endmodule

// File: rtl/minmag_tree.sv
module minmag_tree
    import minmag_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cand_t leaves [MM_NP],
    output cand_t root
);
    for (genvar l = 0; l <= MM_LVL; l++) begin : g_lv
        localparam int unsigned N = MM_NP >> l;
        cand_t nd [N];
        if (l == 0) begin : g_base
            for (genvar n = 0; n < N; n++) begin : g_in
                assign nd[n] = leaves[n];
            end
        end else begin : g_cmp
            for (genvar n = 0; n < N; n++) begin : g_node
                minmag_node u_node (
                    .clk (clk),
                    .rst (rst),
                    .a   (g_lv[l-1].nd[2*n]),
                    .b   (g_lv[l-1].nd[2*n+1]),
                    .y   (nd[n])
                );
            end
        end
    end

    assign root = g_lv[MM_LVL].nd[0];
endmodule

// File: rtl/minmag_result_mem.sv
module minmag_result_mem #(
    parameter int unsigned DW    = 16,
    parameter int unsigned DEPTH = 4096,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/minmag_combiner.sv
module minmag_combiner
    import minmag_pkg::*;
#(
    parameter int unsigned DEPTH = 4096,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rec_start,
    input  logic [AW:0]              cfg_count,
    input  logic [AW-1:0]            cfg_win_start,
    input  logic                     in_valid,
    input  logic [MM_NCH*MM_SW-1:0]  in_data,
    output logic                     out_valid,
    output logic [MM_SW-1:0]         out_sample,
    output logic [MM_CHW-1:0]        out_chan,
    output logic                     rec_done,
    input  logic [AW-1:0]            rd_addr,
    output logic [MM_SW-1:0]         rd_data
);
    cand_t leaves [MM_NP];
    cand_t root;

    minmag_magnitude u_mag (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .leaves   (leaves)
    );

    minmag_tree u_tree (
        .clk    (clk),
        .rst    (rst),
        .leaves (leaves),
        .root   (root)
    );

    assign out_valid  = root.live;
    assign out_sample = root.val;
    assign out_chan   = root.ch;

    // Record start marker travels alongside the data
    logic [MM_LAT-1:0] start_pipe;
    logic [AW:0]       count_q;
    logic [AW-1:0]     win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_pipe <= '0;
            count_q    <= '0;
            win_q      <= '0;
        end else begin
            start_pipe <= {start_pipe[MM_LAT-2:0], rec_start};
            if (rec_start) begin
                count_q <= cfg_count;
                win_q   <= cfg_win_start;
            end
        end
    end

    logic          start_o;
    logic [AW:0]   idx_q, idx_cur, idx_nxt;
    logic          armed_q, armed_cur;
    logic          take, last, wr_en;
    logic [AW-1:0] wr_addr;

    assign start_o   = start_pipe[MM_LAT-1];
    assign idx_cur   = start_o ? '0 : idx_q;
    assign armed_cur = start_o | armed_q;
    assign idx_nxt   = idx_cur + 1'b1;
    assign take      = out_valid && armed_cur && (idx_cur < count_q);
    assign last      = take && (idx_nxt == count_q);
    assign wr_en     = take && (idx_cur >= {1'b0, win_q});
    assign wr_addr   = idx_cur[AW-1:0] - win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q    <= '0;
            armed_q  <= 1'b0;
            rec_done <= 1'b0;
        end else begin
            idx_q    <= take ? idx_nxt : idx_cur;
            armed_q  <= armed_cur && !last;
            rec_done <= last;
        end
    end

    minmag_result_mem #(.DW(MM_SW), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (root.val),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // R5
    lat_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, MM_LAT));

    // R4
    mag_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (root.mag == mm_abs_sat(root.val)));

    // R7
    done_chk: assert property (@(posedge clk) disable iff (rst)
        rec_done |-> ($past(out_valid) && !$past(rec_done)));
endmodule

// File: tb/minmag_combiner_test.sv
module minmag_combiner_test;
    import minmag_pkg::*;

    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst;
    logic rec_start;
    logic [AW:0] cfg_count;
    logic [AW-1:0] cfg_win_start;
    logic in_valid;
    logic [MM_NCH*MM_SW-1:0] in_data;
    logic out_valid;
    logic [MM_SW-1:0] out_sample;
    logic [MM_CHW-1:0] out_chan;
    logic rec_done;
    logic [AW-1:0] rd_addr;
    logic [MM_SW-1:0] rd_data;

    always #5 clk = ~clk;

    minmag_combiner uut (
        .clk(clk), .rst(rst), .rec_start(rec_start), .cfg_count(cfg_count),
        .cfg_win_start(cfg_win_start), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_sample(out_sample), .out_chan(out_chan),
        .rec_done(rec_done), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    typedef struct {
        logic signed [15:0] val;
        int ch;
        int cyc;
    } exp_t;

    exp_t sb [$];
    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int done_cyc = -1;
    bit finished = 0;
    logic signed [15:0] chv [MM_NCH];
    logic signed [15:0] last_val;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int mag_of(logic signed [15:0] v);
        if (v == -16'sd32768) return 32767;
        return (v < 0) ? -int'(v) : int'(v);
    endfunction

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Driver: one input set per call, expected result pushed to the scoreboard
    task automatic send(input bit start);
        exp_t e;
        int best;
        best = 0;
        for (int c = 1; c < MM_NCH; c++)
            if (mag_of(chv[c]) < mag_of(chv[best])) best = c;
        for (int c = 0; c < MM_NCH; c++) in_data[c*16 +: 16] = chv[c];
        in_valid  = 1'b1;
        rec_start = start;
        e.val = chv[best];
        e.ch  = best;
        e.cyc = cyc + MM_LAT;
        last_val = chv[best];
        sb.push_back(e);
        @(negedge clk);
        in_valid  = 1'b0;
        rec_start = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic fill_rand;
        for (int c = 0; c < MM_NCH; c++) chv[c] = 16'($urandom);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Monitor: compares outputs against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(0, "R5 unexpected output", int'(out_sample), 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check($signed(out_sample) == e.val, "R1/R2 value",
                          int'($signed(out_sample)), int'(e.val));
                    check(int'(out_chan) == e.ch, "R3 channel", int'(out_chan), e.ch);
                    check(cyc == e.cyc, "R5 latency cycle", cyc, e.cyc);
                end
            end
            if (rec_done != (cyc == done_cyc))
                check(0, "R7 rec_done", int'(rec_done), int'(cyc == done_cyc));
        end
    end

    task automatic mem_read(input int addr, input logic signed [15:0] expv, input string req);
        rd_addr = AW'(addr);
        @(negedge clk);
        check($signed(rd_data) == expv, req, int'($signed(rd_data)), int'(expv));
    endtask

    logic signed [15:0] rec1 [20];
    logic signed [15:0] rec2 [12];

    initial begin
        rst = 1'b1; rec_start = 0; in_valid = 0; in_data = '0;
        cfg_count = '0; cfg_win_start = '0; rd_addr = '0;
        for (int c = 0; c < MM_NCH; c++) chv[c] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9
        check(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
        check(rec_done == 1'b0, "R9 rec_done after reset", int'(rec_done), 0);

        // R1 / R2: negative winner in the middle
        for (int c = 0; c < MM_NCH; c++) chv[c] = 16'sd1000 + 16'(c);
        chv[6] = -16'sd7;
        send(0);
        // R1: highest channel wins
        for (int c = 0; c < MM_NCH; c++) chv[c] = -16'sd500;
        chv[11] = 16'sd3;
        send(0);
        // R3: opposite-sign tie between ch3 and ch7
        for (int c = 0; c < MM_NCH; c++) chv[c] = 16'sd900;
        chv[7] = -16'sd5; chv[3] = 16'sd5;
        send(0);
        chv[3] = -16'sd5; chv[7] = 16'sd5;
        send(0);
        // R4: most negative ties with +32767, lower channel wins
        for (int c = 0; c < MM_NCH; c++) chv[c] = 16'sd32767;
        chv[0] = -16'sd32768;
        send(0);
        for (int c = 0; c < MM_NCH; c++) chv[c] = -16'sd32768;
        chv[2] = 16'sd32767;
        send(0);
        chv[5] = 16'sd32766;
        send(0);
        // R1: all zero, ch0
        for (int c = 0; c < MM_NCH; c++) chv[c] = '0;
        send(0);
        idle(8);

        // R5: random stream, back-to-back and with gaps
        for (int i = 0; i < 200; i++) begin
            fill_rand();
            send(0);
            if (i % 7 == 3) idle(i % 4);
        end
        idle(10);

        // R6: record 1 fills addresses 0..19
        cfg_count = 13'd20; cfg_win_start = '0;
        for (int i = 0; i < 20; i++) begin
            fill_rand();
            if (i == 19) done_cyc = cyc + MM_LAT + 1;
            send(i == 0);
            rec1[i] = last_val;
        end
        idle(10);
        for (int a = 0; a < 20; a++) mem_read(a, rec1[a], "R6 record1 contents");

        // R6: record 2, count 8, window start 5; extra samples beyond count
        cfg_count = 13'd8; cfg_win_start = 12'd5;
        for (int i = 0; i < 12; i++) begin
            fill_rand();
            if (i == 7) done_cyc = cyc + MM_LAT + 1;
            send(i == 0);
            rec2[i] = last_val;
        end
        idle(10);
        for (int a = 0; a < 3; a++) mem_read(a, rec2[a+5], "R6 windowed write");
        for (int a = 3; a < 20; a++) mem_read(a, rec1[a], "R6 untouched word");

        // R8: read and write of address 0 on the same edge
        rd_addr = '0;
        cfg_count = 13'd1; cfg_win_start = '0;
        for (int c = 0; c < MM_NCH; c++) chv[c] = 16'sd200;
        chv[4] = -16'sd77;
        begin
            int c0;
            c0 = cyc;
            done_cyc = c0 + MM_LAT + 1;
            send(1);
            while (cyc < c0 + MM_LAT + 1) @(negedge clk);
            check($signed(rd_data) == rec2[5], "R8 read on write edge returns old",
                  int'($signed(rd_data)), int'(rec2[5]));
            @(negedge clk);
            check($signed(rd_data) == -16'sd77, "R8 read after write returns new",
                  int'($signed(rd_data)), -77);
        end
        idle(6);
        check(sb.size() == 0, "R5 outputs missing", sb.size(), 0);
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule